// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Divider

This block is the feedback divider of an integer-N frequency synthesizer. It steers an external prescaler that divides its input by either 10 or 11. The prescaler's output reaches the block as a one-cycle tick, `pre_tick`, which acts as a clock enable. Two counters run on those ticks. A 9-bit main setting `m_set` makes one division last M+1 prescaler cycles. A 4-bit swallow setting `a_set` selects how many of those cycles, counted from the start of the division, ask the prescaler to divide by 11. One full division therefore spans 10·(M+1)+A input cycles. At the end of each division the block emits a one-clock pulse.

When `byp_set` is high the prescaler is taken out of the path. Each tick is then one input cycle, and the main counter divides it by M+1 on its own. In this mode the swallow counter stays idle and `mod11` stays low.

The settings are sanitized before use. An M of zero is raised to 1. A swallow count larger than M+1 is clamped to M+1, and the clamp is reported. New settings take effect only at the boundary between two divisions.

Top module: `swallow_divider`

## Requirements
- R1: With bypass low and a prescaler that divides by 11 while `mod11` is high and by 10 otherwise, consecutive `div_pulse` pulses are 10·(M+1)+A input cycles apart.
- R2: `mod11` (1 = divide by 11, 0 = divide by 10) is high for exactly the first A prescaler cycles of each division and low for the remaining ones.
- R3: With bypass high, `div_pulse` comes once every M+1 ticks, `mod11` stays low and `a_set` has no effect.
- R4: When bypass is low and A > M+1, the block uses A = M+1 and holds `a_clamped` high for as long as that setting is active. Otherwise `a_clamped` is low, including in bypass mode.
- R5: An `m_set` of 0 behaves exactly like 1, so the smallest main ratio is 2.
- R6: Changes on `m_set`, `a_set` and `byp_set` take effect only at a division boundary. A division already under way finishes with the old ratio.
- R7: `div_pulse` is high for a single clock, in the clock after the tick that completes a division.
- R8: Synchronous active-high `rst` clears both counters, holds `div_pulse` low and captures the settings present on the inputs, so the first division after reset uses them.
- R9: In clocks without `pre_tick` the counters hold their state, so spacing the ticks two clocks apart doubles the pulse spacing measured in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_tick | input | 1 | Prescaler output tick; with bypass high, one input cycle |
| m_set | input | 9 | Main counter setting M |
| a_set | input | 4 | Swallow count A |
| byp_set | input | 1 | Prescaler bypass request |
| mod11 | output | 1 | Modulus select: 1 = divide by 11, 0 = divide by 10 |
| div_pulse | output | 1 | One-clock pulse per completed division |
| a_clamped | output | 1 | The active swallow count was clamped to M+1 |

## Verification
The bench builds the block with its default widths: a 9-bit main setting and a 4-bit swallow setting. With these widths the largest ratio, 5135, is reachable, and so is the clamp region, where M is 13 or less and A can exceed M+1. A behavioural prescaler in the bench reads `mod11` at the start of each of its cycles. The bench counts input cycles between pulses, which lets it compare every table row's period against 10·(M+1)+A or M+1. It also counts how many divide-by-11 cycles each division contained.

// File: rtl/swd_pkg.sv
package swd_pkg;
  parameter int M_W = 9;
  parameter int A_W = 4;
  localparam int MP_W = M_W + 1;
  typedef logic [M_W-1:0] m_t;
  typedef logic [A_W-1:0] a_t;
endpackage

// File: rtl/swd_cfg_fix.sv
module swd_cfg_fix
  import swd_pkg::*;
(
  input  m_t   m_raw,
  input  a_t   a_raw,
  input  logic byp,
  output m_t   m_fix,
  output a_t   a_fix,
  output logic over
);
  logic [MP_W-1:0] m_plus;
  logic [MP_W-1:0] a_wide;

  always_comb begin
    m_fix  = (m_raw == '0) ? m_t'(1) : m_raw;
    m_plus = MP_W'(m_fix) + MP_W'(1);
    a_wide = MP_W'(a_raw);
    over   = !byp && (a_wide > m_plus);
    if (byp)       a_fix = '0;
    else if (over) a_fix = m_plus[A_W-1:0];
    else           a_fix = a_raw;
  end
endmodule

// File: rtl/swd_count.sv
module swd_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         at_lim
);
  always_comb begin
    if (clr)                      cnt_d = '0;
    else if (en && cnt_q != lim)  cnt_d = cnt_q + W'(1);
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign at_lim = (cnt_q == lim);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tick,
  input  logic [M_W-1:0] m_set,
  input  logic [A_W-1:0] a_set,
  input  logic           byp_set,
  output logic           mod11,
  output logic           div_pulse,
  output logic           a_clamped
);
  m_t   m_fix, act_m, mcnt_q, mcnt_d;
  a_t   a_fix, act_a, scnt_q, scnt_d, nxt_a;
  logic over, act_byp, nxt_byp, m_hit, s_full, bound, load;

  swd_cfg_fix u_fix (
    .m_raw(m_set), .a_raw(a_set), .byp(byp_set),
    .m_fix(m_fix), .a_fix(a_fix), .over(over)
  );

  assign bound = pre_tick && m_hit && !rst;
  assign load  = rst || bound;

  swd_count #(.W(M_W)) u_main (
    .clk(clk), .en(pre_tick), .clr(load), .lim(act_m),
    .cnt_q(mcnt_q), .cnt_d(mcnt_d), .at_lim(m_hit)
  );

  swd_count #(.W(A_W)) u_swal (
    .clk(clk), .en(pre_tick && !act_byp), .clr(load), .lim(act_a),
    .cnt_q(scnt_q), .cnt_d(scnt_d), .at_lim(s_full)
  );

  assign nxt_byp = load ? byp_set : act_byp;
  assign nxt_a   = load ? a_fix   : act_a;

  always_ff @(posedge clk) begin
    if (load) begin
      act_m     <= m_fix;
      act_a     <= a_fix;
      act_byp   <= byp_set;
      a_clamped <= over;
    end
    mod11     <= !nxt_byp && (scnt_d < nxt_a);
    div_pulse <= bound;
  end
endmodule

// File: rtl/swd_chk.sv
module swd_chk
  import swd_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic pre_tick,
  input logic div_pulse,
  input logic mod11,
  input logic a_clamped,
  input m_t   act_m,
  input a_t   act_a,
  input logic act_byp
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  // R7
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(pre_tick));
  // R3
  byp_no_mod11_chk: assert property (@(posedge clk) disable iff (rst)
    act_byp |-> !mod11);
  // R4
  clamp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    MP_W'(act_a) <= MP_W'(act_m) + MP_W'(1));
  // R5
  m_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    act_m != '0);
  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!div_pulse && !$past(rst)) |-> ($stable(act_m) && $stable(act_a)
                                     && $stable(act_byp) && $stable(a_clamped)));
  // R2
  mod11_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(mod11) && !$past(rst)) |-> div_pulse);
endmodule

bind swallow_divider swd_chk u_chk (
  .clk(clk), .rst(rst), .pre_tick(pre_tick), .div_pulse(div_pulse),
  .mod11(mod11), .a_clamped(a_clamped), .act_m(act_m), .act_a(act_a),
  .act_byp(act_byp)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
  logic       clk = 0;
  logic       rst = 1;
  logic       pre_tick = 0;
  logic [8:0] m_set = 9;
  logic [3:0] a_set = 7;
  logic       byp_set = 0;
  logic       mod11, div_pulse, a_clamped;

  int checks = 0, errors = 0, cyc = 0;
  int pulse_cnt = 0, last_stamp = 0, last_n11 = 0, cnt11 = 0;
  int pc = 0, cur_mod = 10;
  bit byp_mode = 0, slow_mode = 0, phase = 0, pend_byp = 0, pend_slow = 0;
  bit done = 0;

  swallow_divider dut (
    .clk(clk), .rst(rst), .pre_tick(pre_tick), .m_set(m_set), .a_set(a_set),
    .byp_set(byp_set), .mod11(mod11), .div_pulse(div_pulse), .a_clamped(a_clamped)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // pulse monitor: stamps pulses, switches the prescaler model at boundaries
  always @(negedge clk) begin
    if (div_pulse) begin
      last_stamp = cyc;
      last_n11   = cnt11;
      cnt11      = 0;
      byp_mode   = pend_byp;
      slow_mode  = pend_slow;
      pc         = 0;
      phase      = 0;
      pulse_cnt  = pulse_cnt + 1;
    end
  end

  // prescaler model: one clock = one input cycle
  initial forever begin
    @(negedge clk);
    #1;
    if (rst) begin
      pc = 0; phase = 0; pre_tick = 0;
    end else if (byp_mode) begin
      if (slow_mode) begin pre_tick = phase; phase = !phase; end
      else pre_tick = 1;
    end else begin
      if (pc == 0) begin
        cur_mod = mod11 ? 11 : 10;
        if (mod11) cnt11 = cnt11 + 1;
      end
      pre_tick = (pc == cur_mod - 1);
      pc = pre_tick ? 0 : pc + 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int stamp);
    int s0 = pulse_cnt;
    wait (pulse_cnt != s0);
    stamp = last_stamp;
  endtask

  function automatic int exp_a(int m, int a, bit b);
    int me = (m == 0) ? 1 : m;
    if (b) return 0;
    return (a > me + 1) ? me + 1 : a;
  endfunction

  typedef struct packed {
    int m; int a; bit byp; bit slow; int per; bit flag;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1, 0, 1'b0, 1'b0, 20, 1'b0},
    '{1, 2, 1'b0, 1'b0, 22, 1'b0},
    '{1, 5, 1'b0, 1'b0, 22, 1'b1},
    '{9, 7, 1'b0, 1'b0, 107, 1'b0},
    '{13, 15, 1'b0, 1'b0, 154, 1'b1},
    '{14, 15, 1'b0, 1'b0, 165, 1'b0},
    '{511, 15, 1'b0, 1'b0, 5135, 1'b0},
    '{3, 9, 1'b1, 1'b0, 4, 1'b0},
    '{511, 0, 1'b1, 1'b0, 512, 1'b0},
    '{0, 0, 1'b0, 1'b0, 20, 1'b0},
    '{0, 4, 1'b1, 1'b0, 2, 1'b0},
    '{3, 0, 1'b1, 1'b1, 8, 1'b0},
    '{0, 3, 1'b0, 1'b0, 22, 1'b1}
  };

  task automatic run_vec(vec_t v);
    int t1, t2;
    m_set = v.m[8:0]; a_set = v.a[3:0]; byp_set = v.byp;
    pend_byp = v.byp; pend_slow = v.slow;
    wait_pulse(t1);
    wait_pulse(t2);
    // R1 R3 R5 R9: period in input cycles
    chk(t2 - t1 == v.per, "R1/R3/R5/R9 period", t2 - t1, v.per);
    // R2: number of divide-by-11 prescaler cycles in the division
    if (!v.byp) chk(last_n11 == exp_a(v.m, v.a, v.byp), "R2 mod11 count",
                    last_n11, exp_a(v.m, v.a, v.byp));
    // R4: clamp flag
    chk(a_clamped == v.flag, "R4 a_clamped", a_clamped, v.flag);
    @(negedge clk);
    // R7: pulse lasts one clock
    chk(div_pulse == 0, "R7 pulse width", div_pulse, 0);
  endtask

  initial begin
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    // R8: reset state with settings captured
    chk(div_pulse == 0, "R8 pulse in reset", div_pulse, 0);
    chk(mod11 == 1, "R8 mod11 captured", mod11, 1);
    chk(a_clamped == 0, "R8 flag captured", a_clamped, 0);
    rst = 0;
    for (int i = 0; i < 13; i++) run_vec(VEC[i]);

    // R6: a change mid-division waits for the boundary
    run_vec('{20, 3, 1'b0, 1'b0, 213, 1'b0});
    wait_pulse(t0);
    repeat (5) @(negedge clk);
    m_set = 2; a_set = 1; byp_set = 0; pend_byp = 0; pend_slow = 0;
    wait_pulse(t1);
    chk(t1 - t0 == 213, "R6 old ratio kept", t1 - t0, 213);
    wait_pulse(t2);
    chk(t2 - t1 == 31, "R6 new ratio after boundary", t2 - t1, 31);

    // R8: reset in the middle of a run
    repeat (4) @(negedge clk);
    rst = 1; m_set = 13; a_set = 15; byp_set = 0;
    pend_byp = 0; pend_slow = 0; byp_mode = 0; slow_mode = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(div_pulse == 0, "R8 pulse held low", div_pulse, 0);
    end
    rst = 0;
    @(negedge clk);
    chk(a_clamped == 1, "R8 R4 flag after reset", a_clamped, 1);
    chk(mod11 == 1, "R8 R2 first cycle divides by 11", mod11, 1);
    wait_pulse(t1);
    wait_pulse(t2);
    chk(t2 - t1 == 154, "R8 period after reset", t2 - t1, 154);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule